// File: doc/BRIEF.md
# I2C Register-File Target with Auto-Increment

This block is an I2C target that serves a bank of nine byte-wide registers, indexed 00h to 08h. A system clock much faster than the bus samples SCL and SDA. Each line passes through a synchroniser and a short glitch filter. A protocol engine then finds START, repeated START and STOP conditions, compares the address byte with a fixed 7-bit device address, and takes the next byte as the register index. It then either stores the incoming bytes or returns register contents to the controller. The target pulls SDA low by asserting an output-enable, and it never stretches the clock.

Registers 00h to 02h are read/write. Their contents leave the block as parallel configuration outputs. Registers 03h to 08h are read-only and show values that the rest of the chip presents on a parallel input. Some bit positions are reserved; they always read as zero and cannot be set. After each byte, the internal index steps forward and wraps from 08h back to 00h. A controller can therefore sweep the whole bank in one transfer, in either direction.

Top module: `i2c_cfg_target`

## Requirements
- R1: While and after reset, every configuration output is 00h and the target does not pull SDA low.
- R2: The target acknowledges an address byte whose upper seven bits are 0010010 (24h = write, 25h = read). For any other address, the target acknowledges nothing and leaves SDA released until the next START, and the bytes that follow change no register.
- R3: In a write, the target acknowledges the register-index byte and every data byte. Each data byte is stored into the register selected by the index, and that register appears on `cfg_o` (register n at bits 8n+7..8n).
- R4: After each data byte in a write, the index advances by one, and it wraps from 08h to 00h.
- R5: A random read is a write of the index byte, then a repeated START, then address 25h. It returns the selected register, most significant bit first.
- R6: During a read, a controller ACK makes the target send the next register, with the index wrapping from 08h to 00h. A controller NACK makes the target release SDA and stop sending.
- R7: Registers 03h to 08h are read-only. Writes to them change no output. A read returns byte k-3 of `ro_i` (bits 8(k-3)+7..8(k-3)) for register k.
- R8: Reserved bits read as zero and cannot be set. The read masks are: 00h 7Fh, 01h 3Fh, 02h FFh, 03h 1Fh, 04h-08h FFh.
- R9: A START or a STOP seen at any point abandons the current transfer. A data byte that is cut short is never written. After a START, the target receives a fresh address byte.
- R10: After synchronisation, a pulse on SCL or SDA shorter than FILT_LEN system clocks (default 3) is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| cfg_o | output | 24 | Read/write registers 00h..02h, register n in byte n |
| ro_i | input | 48 | Read-only registers 03h..08h, register 3+k in byte k |

## Verification
Each pad edge takes two synchroniser flops and FILT_LEN filter cycles to reach the protocol engine. The engine then registers it once for edge detection and once for its response. SDA therefore changes about seven system clocks after the SCL fall that calls for it, and a stored byte reaches `cfg_o` a cycle after the SCL fall that follows its eighth bit. The bench drives each bus quarter-phase as ten system clocks. It samples acknowledges and read bits in the middle of the SCL high phase and reads the configuration outputs only after STOP, so every sample falls well after the latest cycle in which the result is due. A scoreboard matches each observed value against an expectation that was queued from the requirements before the transfer began.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

    localparam int NUM_REGS = 9;
    localparam int NUM_RW   = 3;
    localparam int NUM_RO   = NUM_REGS - NUM_RW;
    localparam int IDX_W    = $clog2(NUM_REGS);

    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_REGA,
        ST_REGA_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK
    } st_e;

    typedef struct packed {
        logic       en;
        idx_t       idx;
        logic [7:0] data;
    } wr_req_t;

    // Implemented bits per register; reserved positions are zero.
    function automatic logic [7:0] bit_mask(input idx_t i);
        logic [7:0] m;
        case (i)
            idx_t'(0): m = 8'h7F;
            idx_t'(1): m = 8'h3F;
            idx_t'(2): m = 8'hFF;
            idx_t'(3): m = 8'h1F;
            default:   m = (int'(i) < NUM_REGS) ? 8'hFF : 8'h00;
        endcase
        return m;
    endfunction

    function automatic idx_t next_idx(input idx_t i);
        return (int'(i) >= NUM_REGS - 1) ? '0 : i + idx_t'(1);
    endfunction

endpackage

// File: rtl/i2c_rb_filt.sv
module i2c_rb_filt #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic line_o
);
    localparam int CNT_W = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       cnt_q;
    logic                   line_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end

    // The output follows the synchronised level only after FILT_LEN agreeing samples.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            line_q <= 1'b1;
        end else if (sync_q[SYNC_STAGES-1] == line_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_W'(FILT_LEN - 1)) begin
            cnt_q  <= '0;
            line_q <= sync_q[SYNC_STAGES-1];
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign line_o = line_q;
endmodule

// File: rtl/i2c_rb_fsm.sv
module i2c_rb_fsm
    import i2c_rb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b0010010
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_f,
    input  logic       sda_f,
    input  logic [7:0] rd_data,
    output logic       sda_oe,
    output wr_req_t    wr,
    output idx_t       ptr,
    output st_e        state,
    output logic       start_p,
    output logic       stop_p
);
    logic       scl_q, sda_q;
    logic       rise, fall;
    st_e        state_q;
    logic [3:0] cnt_q;
    logic [7:0] sh_q, tx_q;
    logic       rw_q, mack_q, oe_q;
    idx_t       ptr_q;
    wr_req_t    wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign start_p = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_p  = scl_f & scl_q & ~sda_q & sda_f;
    assign rise    = scl_f & ~scl_q;
    assign fall    = ~scl_f & scl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
            tx_q    <= '0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
            oe_q    <= 1'b0;
            ptr_q   <= '0;
            wr_q    <= '0;
        end else begin
            wr_q.en <= 1'b0;
            if (stop_p) begin
                state_q <= ST_IDLE;
                oe_q    <= 1'b0;
            end else if (start_p) begin
                state_q <= ST_ADDR;
                cnt_q   <= '0;
                oe_q    <= 1'b0;
            end else begin
                if (rise) begin
                    case (state_q)
                        ST_ADDR, ST_REGA, ST_WDATA: begin
                            sh_q  <= {sh_q[6:0], sda_f};
                            cnt_q <= cnt_q + 4'd1;
                        end
                        ST_RDATA: cnt_q  <= cnt_q + 4'd1;
                        ST_RACK:  mack_q <= ~sda_f;
                        default: ;
                    endcase
                end
                if (fall) begin
                    case (state_q)
                        ST_ADDR: if (cnt_q == 4'd8) begin
                            if (sh_q[7:1] == DEV_ADDR) begin
                                oe_q    <= 1'b1;
                                rw_q    <= sh_q[0];
                                state_q <= ST_ADDR_ACK;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                        ST_ADDR_ACK: begin
                            cnt_q <= '0;
                            if (rw_q) begin
                                tx_q    <= rd_data;
                                oe_q    <= ~rd_data[7];
                                state_q <= ST_RDATA;
                            end else begin
                                oe_q    <= 1'b0;
                                state_q <= ST_REGA;
                            end
                        end
                        ST_REGA: if (cnt_q == 4'd8) begin
                            ptr_q   <= sh_q[IDX_W-1:0];
                            oe_q    <= 1'b1;
                            state_q <= ST_REGA_ACK;
                        end
                        ST_REGA_ACK, ST_WDATA_ACK: begin
                            oe_q    <= 1'b0;
                            cnt_q   <= '0;
                            state_q <= ST_WDATA;
                        end
                        ST_WDATA: if (cnt_q == 4'd8) begin
                            wr_q    <= '{en: 1'b1, idx: ptr_q, data: sh_q};
                            ptr_q   <= next_idx(ptr_q);
                            oe_q    <= 1'b1;
                            state_q <= ST_WDATA_ACK;
                        end
                        ST_RDATA: begin
                            if (cnt_q == 4'd8) begin
                                oe_q    <= 1'b0;
                                ptr_q   <= next_idx(ptr_q);
                                state_q <= ST_RACK;
                            end else begin
                                oe_q <= ~tx_q[3'd7 - cnt_q[2:0]];
                            end
                        end
                        ST_RACK: begin
                            if (mack_q) begin
                                tx_q    <= rd_data;
                                oe_q    <= ~rd_data[7];
                                cnt_q   <= '0;
                                state_q <= ST_RDATA;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    assign sda_oe = oe_q;
    assign wr     = wr_q;
    assign ptr    = ptr_q;
    assign state  = state_q;
endmodule

// File: rtl/i2c_rb_regs.sv
module i2c_rb_regs
    import i2c_rb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  wr_req_t               wr,
    input  idx_t                  rd_idx,
    input  logic [NUM_RO*8-1:0]   ro_i,
    output logic [NUM_RW*8-1:0]   cfg_o,
    output logic [7:0]            rd_data
);
    logic [7:0] rw_q [NUM_RW];

    for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
        always_ff @(posedge clk) begin
            if (rst) begin
                rw_q[g] <= '0;
            end else if (wr.en && wr.idx == idx_t'(g)) begin
                rw_q[g] <= wr.data & bit_mask(idx_t'(g));
            end
        end
        assign cfg_o[g*8 +: 8] = rw_q[g];
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_RW; i++) begin
            if (rd_idx == idx_t'(i)) rd_data = rw_q[i];
        end
        for (int i = 0; i < NUM_RO; i++) begin
            if (rd_idx == idx_t'(i + NUM_RW))
                rd_data = ro_i[i*8 +: 8] & bit_mask(idx_t'(i + NUM_RW));
        end
    end
endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
    import i2c_rb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b0010010,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe_o,
    output logic [NUM_RW*8-1:0] cfg_o,
    input  logic [NUM_RO*8-1:0] ro_i
);
    logic [1:0] pin_raw, pin_flt;
    logic       scl_f, sda_f;
    logic [7:0] rd_data;
    wr_req_t    wr_req;
    idx_t       ptr;
    st_e        state;
    logic       start_p, stop_p;

    assign pin_raw = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_line
        i2c_rb_filt #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk   (clk),
            .rst   (rst),
            .pin_i (pin_raw[g]),
            .line_o(pin_flt[g])
        );
    end

    assign scl_f = pin_flt[0];
    assign sda_f = pin_flt[1];

    i2c_rb_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .scl_f  (scl_f),
        .sda_f  (sda_f),
        .rd_data(rd_data),
        .sda_oe (sda_oe_o),
        .wr     (wr_req),
        .ptr    (ptr),
        .state  (state),
        .start_p(start_p),
        .stop_p (stop_p)
    );

    i2c_rb_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr_req),
        .rd_idx (ptr),
        .ro_i   (ro_i),
        .cfg_o  (cfg_o),
        .rd_data(rd_data)
    );
endmodule

// File: rtl/i2c_rb_chk.sv
module i2c_rb_chk
    import i2c_rb_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                scl_f,
    input logic                sda_oe,
    input wr_req_t             wr,
    input idx_t                ptr,
    input st_e                 state,
    input logic                start_p,
    input logic                stop_p,
    input logic [NUM_RW*8-1:0] cfg
);
    AST_OE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> (!$past(scl_f) || $past(start_p) || $past(stop_p))); // R3

    AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        wr.en |=> !wr.en); // R3

    AST_PTR_WRAPS: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.idx == idx_t'(NUM_REGS - 1)) |-> (ptr == '0)); // R4

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe); // R2

    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (rst)
        (start_p && !stop_p) |=> (state == ST_ADDR)); // R9

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        stop_p |=> (state == ST_IDLE)); // R9

    AST_CFG_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        (cfg != $past(cfg)) |-> $past(wr.en)); // R7
endmodule

bind i2c_cfg_target i2c_rb_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .scl_f  (scl_f),
    .sda_oe (sda_oe_o),
    .wr     (wr_req),
    .ptr    (ptr),
    .state  (state),
    .start_p(start_p),
    .stop_p (stop_p),
    .cfg    (cfg_o)
);

// File: tb/i2c_cfg_target_tb.sv
module i2c_cfg_target_tb;
    localparam int T = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_oe;
    logic [23:0] cfg;
    logic [47:0] ro = 48'hA5_5A_C3_3C_96_E7;
    wire         sda_line = sda_m & ~sda_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0] exp_q [$];
    logic [7:0] obs_q [$];
    string      tag_q [$];

    always #5 clk = ~clk;

    i2c_cfg_target u_dut (
        .clk     (clk),
        .rst     (rst),
        .scl_i   (scl_m),
        .sda_i   (sda_line),
        .sda_oe_o(sda_oe),
        .cfg_o   (cfg),
        .ro_i    (ro)
    );

    // Scoreboard monitor: pairs each observation with the oldest expectation.
    initial begin : monitor
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0 && exp_q.size() > 0) begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic logic [7:0] a = obs_q.pop_front();
                automatic string      t = tag_q.pop_front();
                n_tests++;
                if (a !== e) begin
                    n_fail++;
                    $display("FAIL %s actual=%02h expected=%02h", t, a, e);
                end
            end
        end
    end

    task automatic expect_v(input string tag, input logic [7:0] v);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic observe(input logic [7:0] v);
        obs_q.push_back(v);
    endtask

    task automatic dly(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_w(input logic b);
        sda_m = b; dly(T);
        scl_m = 1'b1; dly(2*T);
        scl_m = 1'b0; dly(T);
    endtask

    // kind 1: short SDA dip while SCL high; kind 2: short SCL spike while low.
    task automatic bit_w_g(input logic b, input int kind);
        sda_m = b;
        if (kind == 2) begin
            dly(3); scl_m = 1'b1; dly(2); scl_m = 1'b0; dly(T-5);
        end else begin
            dly(T);
        end
        scl_m = 1'b1; dly(T);
        if (kind == 1) begin
            sda_m = 1'b0; dly(2); sda_m = b; dly(T-2);
        end else begin
            dly(T);
        end
        scl_m = 1'b0; dly(T);
    endtask

    task automatic bit_r(output logic b);
        sda_m = 1'b1; dly(T);
        scl_m = 1'b1; dly(T);
        b = sda_line; dly(T);
        scl_m = 1'b0; dly(T);
    endtask

    task automatic do_start();
        sda_m = 1'b0; dly(T);
        scl_m = 1'b0; dly(T);
    endtask

    task automatic do_rstart();
        sda_m = 1'b1; dly(T);
        scl_m = 1'b1; dly(T);
        sda_m = 1'b0; dly(T);
        scl_m = 1'b0; dly(T);
    endtask

    task automatic do_stop();
        sda_m = 1'b0; dly(T);
        scl_m = 1'b1; dly(T);
        sda_m = 1'b1; dly(2*T);
    endtask

    // Sends a byte; expects an acknowledge when exp_ack is 1.
    task automatic send(input string tag, input logic [7:0] v, input logic exp_ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_w(v[i]);
        bit_r(a);
        expect_v(tag, {7'd0, exp_ack});
        observe({7'd0, ~a});
    endtask

    task automatic recv(input string tag, input logic [7:0] exp, input logic mack);
        logic [7:0] v;
        logic       b;
        for (int i = 7; i >= 0; i--) begin
            bit_r(b);
            v[i] = b;
        end
        expect_v(tag, exp);
        observe(v);
        bit_w(~mack);
    endtask

    task automatic check_cfg(input string tag, input int idx, input logic [7:0] exp);
        @(negedge clk);
        expect_v(tag, exp);
        observe(cfg[idx*8 +: 8]);
    endtask

    initial begin : main
        logic [7:0] wv [9] = '{8'hAB, 8'hCD, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h12};
        dly(2);
        // R1: reset state
        check_cfg("R1", 0, 8'h00);
        check_cfg("R1", 1, 8'h00);
        check_cfg("R1", 2, 8'h00);
        expect_v("R1", 8'h00); observe({7'd0, sda_oe});
        dly(3);
        rst = 1'b0;
        dly(20);
        check_cfg("R1", 0, 8'h00);

        // R3, R8: single write, reserved bit 7 of 00h stays clear
        do_start();
        send("R2", 8'h24, 1'b1);
        send("R3", 8'h00, 1'b1);
        send("R3", 8'hFF, 1'b1);
        do_stop();
        check_cfg("R8", 0, 8'h7F);

        // R4, R7: burst from 01h over read-only range, wrapping to 00h
        do_start();
        send("R2", 8'h24, 1'b1);
        send("R4", 8'h01, 1'b1);
        for (int i = 0; i < 9; i++) send("R3", wv[i], 1'b1);
        do_stop();
        check_cfg("R4", 0, 8'h12);
        check_cfg("R8", 1, 8'h2B);
        check_cfg("R7", 2, 8'hCD);

        // R5: random read of 02h
        do_start();
        send("R5", 8'h24, 1'b1);
        send("R5", 8'h02, 1'b1);
        do_rstart();
        send("R5", 8'h25, 1'b1);
        recv("R5", 8'hCD, 1'b0);
        do_stop();

        // R7, R8: read-only 03h with masked reserved bits
        do_start();
        send("R7", 8'h24, 1'b1);
        send("R7", 8'h03, 1'b1);
        do_rstart();
        send("R7", 8'h25, 1'b1);
        recv("R7", 8'h07, 1'b0);
        do_stop();

        // R6: sequential read 06h..01h through the wrap, NACK ends it
        do_start();
        send("R6", 8'h24, 1'b1);
        send("R6", 8'h06, 1'b1);
        do_rstart();
        send("R6", 8'h25, 1'b1);
        recv("R6", 8'hC3, 1'b1);
        recv("R7", 8'h5A, 1'b1);
        recv("R6", 8'hA5, 1'b1);
        recv("R6", 8'h12, 1'b1);
        recv("R6", 8'h2B, 1'b0);
        dly(T);
        expect_v("R6", 8'h00); observe({7'd0, sda_oe});
        do_stop();

        // R2: foreign address is ignored, no acknowledges, no writes
        do_start();
        send("R2", 8'h26, 1'b0);
        send("R2", 8'h00, 1'b0);
        send("R2", 8'h55, 1'b0);
        do_stop();
        check_cfg("R2", 0, 8'h12);

        // R9: repeated START mid data byte; partial byte not written
        do_start();
        send("R9", 8'h24, 1'b1);
        send("R9", 8'h00, 1'b1);
        for (int i = 0; i < 4; i++) bit_w(1'b1);
        do_rstart();
        send("R9", 8'h24, 1'b1);
        send("R9", 8'h02, 1'b1);
        send("R9", 8'h44, 1'b1);
        do_stop();
        check_cfg("R9", 0, 8'h12);
        check_cfg("R9", 2, 8'h44);

        // R9: STOP inside the address byte, then a normal read works
        do_start();
        for (int i = 0; i < 3; i++) bit_w(1'b0);
        do_stop();
        do_start();
        send("R9", 8'h24, 1'b1);
        send("R9", 8'h00, 1'b1);
        do_rstart();
        send("R9", 8'h25, 1'b1);
        recv("R9", 8'h12, 1'b0);
        do_stop();

        // R10: short glitches on both lines during a write of 3Ch to 01h
        do_start();
        send("R10", 8'h24, 1'b1);
        send("R10", 8'h01, 1'b1);
        begin
            logic [7:0] gv = 8'h3C;
            logic a;
            for (int i = 7; i >= 0; i--) begin
                if (i == 5)      bit_w_g(gv[i], 1);
                else if (i == 2) bit_w_g(gv[i], 2);
                else             bit_w(gv[i]);
            end
            bit_r(a);
            expect_v("R10", 8'h01); observe({7'd0, ~a});
        end
        do_stop();
        check_cfg("R10", 1, 8'h3C);

        dly(10);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule